// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Subset Core

This block is a small processor that completes one instruction per clock. Every cycle it takes a word from its instruction store at the address held in the program counter. It splits that word into fixed fields, reads up to two source registers and computes a result or a data address. It then writes the result back and selects the next program counter. Instructions come in three 32-bit shapes. The register shape names two sources and a destination and selects the operation in a low function field. The immediate shape carries one source, one target and a 16-bit constant. The jump shape carries a 26-bit word target.

The supported operations are add, subtract, signed set-less-than, the immediate forms of add, set-less-than, AND and OR, load-upper, word load and store, the two equality branches, and the absolute jump. A 32-bit constant takes two instructions: load-upper, then OR-immediate into the low half. Memory is addressed in bytes and accessed in aligned words.

A bench writes both memories through a shared load port while reset holds the core. It then releases reset and reads architectural registers through a combinational debug read port.

Top module: `sc_core`

## Requirements
- R1: Register 0 always reads as zero; any instruction that names it as destination leaves it unchanged.
- R2: A synchronous, active-high reset clears the program counter and all 32 registers to zero. Every instruction other than a taken branch or a jump advances the program counter by 4.
- R3: Register-shape instructions use op=bits[31:26]=0, rs=[25:21], rt=[20:16], rd=[15:11], funct=[5:0]. funct 32 writes rs+rt to rd, and funct 34 writes rs−rt to rd.
- R4: funct 42 writes 1 to rd when rs<rt as signed values and 0 otherwise. Opcode 10 does the same comparison against the sign-extended immediate and writes rt.
- R5: Opcode 8 adds the sign-extended immediate bits[15:0] to rs. Opcode 12 ANDs and opcode 13 ORs rs with the zero-extended immediate. All three write rt.
- R6: Opcode 15 writes {imm16, 16'h0000} to rt, so that it followed by opcode 13 on the same register builds a full 32-bit constant.
- R7: Opcode 35 loads and opcode 43 stores the word at byte address rs + sign-extended immediate, with word index = address[..:2]. The load writes rt, and the store takes its data from rt.
- R8: Opcode 4 branches when rs equals rt, and opcode 5 branches when they differ. The target is PC+4 + (sign-extended imm16 << 2), which may be backward. When the branch is not taken, the PC becomes PC+4.
- R9: Opcode 2 sets the PC to {(PC+4)[31:28], bits[25:0], 2'b00}.
- R10: An unknown opcode, or opcode 0 with an unknown funct, writes no register and no memory and advances the PC by 4.
- R11: While ld_imem_we or ld_dmem_we is high, ld_data is written into the instruction or data memory word at index ld_addr. A data-memory load-port write takes priority over a store.
- R12: dbg_val combinationally returns the register selected by dbg_sel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_imem_we | input | 1 | Load-port write into instruction memory |
| ld_dmem_we | input | 1 | Load-port write into data memory |
| ld_addr | input | MEM_AW | Word index for load-port writes |
| ld_data | input | 32 | Word written by the load port |
| dbg_sel | input | 5 | Register number to observe |
| dbg_val | output | 32 | Contents of the selected register |

## Verification
On every cycle the assertions check several properties: register 0 stays zero, reset brings the PC to zero, and the PC stays word aligned. They also check that non-control instructions and untaken branches step the PC by exactly 4, and that a jump lands on its 26-bit field. Arithmetic results, sign and zero extension, the constant build, store-then-load through memory, backward branches, and the skipping of instructions behind taken branches and jumps are visible only through the final register contents. The bench program is arranged to expose these, with skipped instructions writing registers that must remain zero.

// File: rtl/sc_core.sv
module sc_core #(
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_imem_we,
  input  logic              ld_dmem_we,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [31:0]       ld_data,
  input  logic [4:0]        dbg_sel,
  output logic [31:0]       dbg_val
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [31:0] imem [DEPTH];
  logic [31:0] dmem [DEPTH];
  logic [31:0] rf [32];
  logic [31:0] pc, pc_nx, pc4, instr;

  logic [5:0]  op, funct;
  logic [4:0]  rs, rt, rd, wr_idx;
  logic [15:0] imm;
  logic [31:0] simm, zimm, rs_val, rt_val, addr, br_tgt, wr_val;
  logic [MEM_AW-1:0] dword;
  logic        wr_en, is_sw;

  assign instr  = imem[MEM_AW'(pc >> 2)];
  assign op     = instr[31:26];
  assign rs     = instr[25:21];
  assign rt     = instr[20:16];
  assign rd     = instr[15:11];
  assign funct  = instr[5:0];
  assign imm    = instr[15:0];
  assign simm   = {{16{imm[15]}}, imm};
  assign zimm   = {16'h0000, imm};
  assign rs_val = rf[rs];
  assign rt_val = rf[rt];
  assign addr   = rs_val + simm;
  assign dword  = MEM_AW'(addr >> 2);
  assign pc4    = pc + 32'd4;
  assign br_tgt = pc4 + {simm[29:0], 2'b00};
  assign dbg_val = rf[dbg_sel];

  always_comb begin
    wr_en  = 1'b0;
    wr_idx = rt;
    wr_val = '0;
    is_sw  = 1'b0;
    pc_nx  = pc4;
    case (op)
      6'd0: begin
        wr_idx = rd;
        case (funct)
          6'd32: begin wr_en = 1'b1; wr_val = rs_val + rt_val; end
          6'd34: begin wr_en = 1'b1; wr_val = rs_val - rt_val; end
          6'd42: begin wr_en = 1'b1; wr_val = {31'd0, $signed(rs_val) < $signed(rt_val)}; end
          default: ;
        endcase
      end
      6'd8:  begin wr_en = 1'b1; wr_val = rs_val + simm; end
      6'd10: begin wr_en = 1'b1; wr_val = {31'd0, $signed(rs_val) < $signed(simm)}; end
      6'd12: begin wr_en = 1'b1; wr_val = rs_val & zimm; end
      6'd13: begin wr_en = 1'b1; wr_val = rs_val | zimm; end
      6'd15: begin wr_en = 1'b1; wr_val = {imm, 16'h0000}; end
      6'd35: begin wr_en = 1'b1; wr_val = dmem[dword]; end
      6'd43: is_sw = 1'b1;
      6'd4:  if (rs_val == rt_val) pc_nx = br_tgt;
      6'd5:  if (rs_val != rt_val) pc_nx = br_tgt;
      6'd2:  pc_nx = {pc4[31:28], instr[25:0], 2'b00};
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
      for (int i = 0; i < 32; i++) rf[i] <= '0;
    end else begin
      pc <= pc_nx;
      if (wr_en && wr_idx != 5'd0) rf[wr_idx] <= wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_imem_we) imem[ld_addr] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (ld_dmem_we) dmem[ld_addr] <= ld_data;
    else if (!rst && is_sw) dmem[dword] <= rt_val;
  end
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val,
  input logic [31:0] reg0
);
  logic [5:0] op;
  logic       seq_op, br_not;
  assign op     = instr[31:26];
  assign seq_op = (op != 6'd2) && (op != 6'd4) && (op != 6'd5);
  assign br_not = (op == 6'd4 && rs_val != rt_val) || (op == 6'd5 && rs_val == rt_val);

  // R1
  reg0_zero_chk: assert property (@(posedge clk) disable iff (rst) reg0 == 32'd0);

  // R2
  pc_reset_chk: assert property (@(posedge clk) rst |=> pc == 32'd0);

  // R2
  pc_align_chk: assert property (@(posedge clk) disable iff (rst) pc[1:0] == 2'b00);

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    seq_op |=> pc == $past(pc) + 32'd4);

  // R8
  br_fall_chk: assert property (@(posedge clk) disable iff (rst)
    br_not |=> pc == $past(pc) + 32'd4);

  // R9
  jump_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    op == 6'd2 |=> pc[27:0] == {$past(instr[25:0]), 2'b00});
endmodule

bind sc_core sc_core_chk u_chk (
  .clk(clk), .rst(rst), .pc(pc), .instr(instr),
  .rs_val(rs_val), .rt_val(rt_val), .reg0(rf[0])
);

// File: tb/sim_sc_core.sv
`timescale 1ns/1ps
module sim_sc_core;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_imem_we = 1'b0, ld_dmem_we = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [31:0]   ld_data = '0;
  logic [4:0]    dbg_sel = '0;
  logic [31:0]   dbg_val;

  int n_run = 0, n_fail = 0, n_push = 0;
  bit done = 0;

  typedef struct { int idx; logic [31:0] val; string tag; } exp_t;
  exp_t sb[$];

  sc_core #(.MEM_AW(AW)) u0 (
    .clk(clk), .rst(rst), .ld_imem_we(ld_imem_we), .ld_dmem_we(ld_dmem_we),
    .ld_addr(ld_addr), .ld_data(ld_data), .dbg_sel(dbg_sel), .dbg_val(dbg_val)
  );

  always #2 clk = ~clk;

  function automatic logic [31:0] rt3(int f, int s, int t, int d);
    return {6'd0, 5'(s), 5'(t), 5'(d), 5'd0, 6'(f)};
  endfunction
  function automatic logic [31:0] it(int o, int s, int t, int imm);
    return {6'(o), 5'(s), 5'(t), 16'(imm)};
  endfunction
  function automatic logic [31:0] jt(int w);
    return {6'd2, 26'(w)};
  endfunction

  task automatic load(input bit to_i, input int a, input logic [31:0] d);
    @(negedge clk);
    ld_imem_we = to_i; ld_dmem_we = !to_i; ld_addr = AW'(a); ld_data = d;
    @(negedge clk);
    ld_imem_we = 0; ld_dmem_we = 0;
  endtask

  task automatic expect_reg(input int idx, input logic [31:0] v, input string tag);
    exp_t e;
    e.idx = idx; e.val = v; e.tag = tag;
    sb.push_back(e);
    n_push++;
  endtask

  task automatic drain();
    wait (n_run == n_push);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      wait (n_push > n_run);
      e = sb.pop_front();
      @(negedge clk);
      dbg_sel = 5'(e.idx);
      #1;
      if (dbg_val !== e.val) begin
        n_fail++;
        $display("FAIL %s: r%0d actual %h expected %h", e.tag, e.idx, dbg_val, e.val);
      end
      n_run++;
    end
  end

  initial begin : driver
    logic [31:0] prog [35];
    prog[0]  = it(15, 0, 1, 16'h1234);
    prog[1]  = it(13, 1, 1, 16'h5678);
    prog[2]  = it(8, 0, 2, -5);
    prog[3]  = it(8, 0, 3, 7);
    prog[4]  = rt3(32, 2, 3, 4);
    prog[5]  = rt3(34, 2, 3, 5);
    prog[6]  = rt3(42, 2, 3, 6);
    prog[7]  = rt3(42, 3, 2, 7);
    prog[8]  = it(10, 2, 8, -4);
    prog[9]  = it(12, 2, 9, 16'hFF00);
    prog[10] = it(13, 0, 10, 16'h8001);
    prog[11] = it(8, 0, 0, 99);
    prog[12] = it(8, 0, 11, 16);
    prog[13] = it(43, 11, 1, -4);
    prog[14] = it(35, 0, 12, 12);
    prog[15] = it(35, 0, 13, 4);
    prog[16] = it(4, 3, 3, 2);
    prog[17] = it(8, 0, 14, 1);
    prog[18] = it(8, 0, 14, 2);
    prog[19] = it(5, 3, 3, 1);
    prog[20] = it(8, 0, 15, 3);
    prog[21] = it(5, 2, 3, 1);
    prog[22] = it(8, 0, 15, 4);
    prog[23] = it(4, 2, 3, 1);
    prog[24] = it(8, 0, 16, 5);
    prog[25] = {6'd63, 5'd0, 5'd17, 16'h1234};
    prog[26] = rt3(1, 3, 3, 18);
    prog[27] = jt(30);
    prog[28] = it(8, 0, 19, 1);
    prog[29] = it(8, 0, 19, 2);
    prog[30] = it(8, 0, 20, 6);
    prog[31] = it(8, 21, 21, 1);
    prog[32] = it(10, 21, 22, 3);
    prog[33] = it(5, 22, 0, -3);
    prog[34] = jt(34);

    repeat (3) @(negedge clk);
    expect_reg(5, 32'h0, "R2 reset clears registers");
    expect_reg(1, 32'h0, "R2 reset clears registers");
    drain();
    for (int i = 0; i < 35; i++) load(1, i, prog[i]);
    load(0, 1, 32'hCAFE_F00D);
    load(0, 3, 32'h0);
    @(negedge clk); rst = 0;
    repeat (150) @(negedge clk);

    expect_reg(1,  32'h1234_5678, "R6 lui+ori constant");
    expect_reg(2,  32'hFFFF_FFFB, "R5 addi sign-extend");
    expect_reg(3,  32'd7,         "R5 addi positive");
    expect_reg(4,  32'd2,         "R3 add");
    expect_reg(5,  32'hFFFF_FFF4, "R3 sub");
    expect_reg(6,  32'd1,         "R4 slt signed true");
    expect_reg(7,  32'd0,         "R4 slt signed false");
    expect_reg(8,  32'd1,         "R4 slti signed");
    expect_reg(9,  32'h0000_FF00, "R5 andi zero-extend");
    expect_reg(10, 32'h0000_8001, "R5 ori zero-extend");
    expect_reg(0,  32'd0,         "R1 write to r0 ignored");
    expect_reg(12, 32'h1234_5678, "R7 sw negative offset then lw");
    expect_reg(13, 32'hCAFE_F00D, "R11 data preloaded by load port");
    expect_reg(14, 32'd0,         "R8 beq taken skips");
    expect_reg(15, 32'd3,         "R8 bne not taken / taken skip");
    expect_reg(16, 32'd5,         "R8 beq not taken falls through");
    expect_reg(17, 32'd0,         "R10 unknown opcode no write");
    expect_reg(18, 32'd0,         "R10 unknown funct no write");
    expect_reg(19, 32'd0,         "R9 jump skips");
    expect_reg(20, 32'd6,         "R9 jump target executes");
    expect_reg(21, 32'd3,         "R8 backward branch loop count");
    expect_reg(22, 32'd0,         "R12 debug read of loop flag");
    drain();

    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    expect_reg(1,  32'd0, "R2 reset after run");
    expect_reg(21, 32'd0, "R2 reset after run");
    drain();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end
endmodule